// File: doc/BRIEF.md
# SDRAM Power-Up Command Sequencer

This block walks a memory controller through the command series that an SDRAM or DDR SDRAM needs before it may enter normal operation. A start pulse, taken while the block is idle, captures the configuration (memory variant, high-address mode, the base control word and the two mode words). The block then offers one command at a time on a valid/ready interface. Each command is either a control word bound for the controller's command register or a word bound for the device mode registers.

The control word carries three fields whose positions the downstream controller decodes. Bit 31 unlocks the mode register. Bit 24 selects high-address mode. Bits 2:0 hold the command code: 0 for none, 2 for precharge-all and 4 for auto-refresh. Every other bit is copied from the base control word. The DDR variant adds an extended-mode load, a DLL reset and a second precharge-all. Because the high-address bit travels with every control word, a size-probing routine can run the whole series once in each address mode.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is low, and while idle with no start, `cmd_valid` and `done` stay low. Accepting on `cmd_ready` has no effect while idle. A reset in the middle of a sequence returns the block to idle at the next clock edge.
- R2: A start pulse taken while idle makes the first command visible one clock edge later. That command is a control word (`cmd_to_mode`=0) with bit 31 set and code bits 2:0 equal to 0.
- R3: With `ddr_sel`=0 the commands are, in order: unlock, precharge-all (bit 31 set, code 2), auto-refresh (bit 31 set, code 4), mode load (`cmd_to_mode`=1, word equal to `mode_word`), and normal operation (bit 31 clear, code 0).
- R4: With `ddr_sel`=1 the order is: unlock, precharge-all, extended-mode load (`ext_mode_word`), DLL reset (`mode_word` with bit 26 set), precharge-all, auto-refresh, mode load, normal operation.
- R5: In every control word, bit 24 equals the `hi_addr` value captured at start. All bits other than 31, 24 and 2:0 equal the captured `ctrl_base`. Mode-register words are passed through with no change apart from the DLL-reset bit.
- R6: A command offered without `cmd_ready` stays valid with an unchanged word and target until it is accepted.
- R7: `done` is high for exactly one cycle, one clock edge after the normal-operation command is accepted. In that cycle `cmd_valid` is low.
- R8: Start pulses and changes to any configuration input have no effect while a sequence is running.
- R9: The next command is valid one clock edge after the previous command is accepted, so commands can be accepted back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a sequence (taken only while idle) |
| ddr_sel | input | 1 | 1 selects the DDR variant, 0 the single-rate variant |
| hi_addr | input | 1 | High-address mode, copied into bit 24 of control words |
| ctrl_base | input | 32 | Base control word |
| mode_word | input | 32 | Normal mode-register word |
| ext_mode_word | input | 32 | Extended mode-register word |
| cmd_valid | output | 1 | A command is offered |
| cmd_ready | input | 1 | The downstream accepts the offered command |
| cmd_to_mode | output | 1 | 1 when the word targets the mode register, 0 for the control register |
| cmd_word | output | 32 | Command or mode word |
| done | output | 1 | One-cycle pulse after the final command is accepted |

## Verification
The first command appears one rising edge after the start pulse. Each later command appears one rising edge after the edge that accepted its predecessor. `done` rises one edge after the normal-operation command is accepted and falls on the following edge. The bench drives inputs and samples outputs on the falling edge, so every value it reads has settled after exactly the edges counted above. The bench can stall the handshake for a chosen number of cycles, and it checks at each stalled falling edge that the command has not moved.

// File: rtl/sdinit_pkg.sv
// Package: shared step encoding and step-order helpers for the SDRAM
// power-up sequencer. Assumes a single sequence is ever in flight.
package sdinit_pkg;

    typedef enum logic [3:0] {
        ST_IDLE   = 4'd0,
        ST_UNLOCK = 4'd1,
        ST_PRE1   = 4'd2,
        ST_EMODE  = 4'd3,
        ST_DLLRST = 4'd4,
        ST_PRE2   = 4'd5,
        ST_AREF   = 4'd6,
        ST_MODE   = 4'd7,
        ST_NORMAL = 4'd8
    } step_e;

    // Successor of a step; the single-rate variant skips the DDR-only steps.
    function automatic step_e step_after(step_e s, logic ddr);
        case (s)
            ST_UNLOCK: return ST_PRE1;
            ST_PRE1:   return ddr ? ST_EMODE : ST_AREF;
            ST_EMODE:  return ST_DLLRST;
            ST_DLLRST: return ST_PRE2;
            ST_PRE2:   return ST_AREF;
            ST_AREF:   return ST_MODE;
            ST_MODE:   return ST_NORMAL;
            default:   return ST_IDLE;
        endcase
    endfunction

    // True for steps that write a mode register rather than the control register.
    function automatic logic targets_mode(step_e s);
        return (s == ST_EMODE) || (s == ST_DLLRST) || (s == ST_MODE);
    endfunction

endpackage

// File: rtl/sdinit_cfg_latch.sv
// Configuration capture: holds variant, address mode and words for the whole
// sequence. Assumes capture is only asserted while the sequencer is idle.
module sdinit_cfg_latch #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         capture,
    input  logic         d_ddr,
    input  logic         d_hi,
    input  logic [W-1:0] d_base,
    input  logic [W-1:0] d_mode,
    input  logic [W-1:0] d_emode,
    output logic         q_ddr,
    output logic         q_hi,
    output logic [W-1:0] q_base,
    output logic [W-1:0] q_mode,
    output logic [W-1:0] q_emode
);

    // Register the configuration on capture; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_ddr   <= 1'b0;
            q_hi    <= 1'b0;
            q_base  <= '0;
            q_mode  <= '0;
            q_emode <= '0;
        end else if (capture) begin
            q_ddr   <= d_ddr;
            q_hi    <= d_hi;
            q_base  <= d_base;
            q_mode  <= d_mode;
            q_emode <= d_emode;
        end
    end

endmodule

// File: rtl/sdinit_seq_fsm.sv
// Step sequencer: advances one step per accepted command and pulses done
// after the last one. Assumes the ddr input is stable while busy.
module sdinit_seq_fsm
    import sdinit_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start,
    input  logic  ddr,
    input  logic  accept,
    output step_e step,
    output logic  busy,
    output logic  capture,
    output logic  done
);

    // Idle detection and start qualification.
    always_comb begin
        busy    = (step != ST_IDLE);
        capture = start && !busy;
    end

    // Step register and one-cycle completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step <= ST_IDLE;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (capture) begin
                step <= ST_UNLOCK;
            end else if (busy && accept) begin
                if (step == ST_NORMAL) begin
                    done <= 1'b1;
                end
                step <= step_after(step, ddr);
            end
        end
    end

endmodule

// File: rtl/sdinit_word_mux.sv
// Word composer: builds the control or mode word for the current step.
// Assumes the field positions are distinct and the code field sits at bit 0.
module sdinit_word_mux
    import sdinit_pkg::*;
#(
    parameter int W          = 32,
    parameter int UNLOCK_BIT = 31,
    parameter int HIADDR_BIT = 24,
    parameter int DLLRST_BIT = 26,
    parameter int CODE_W     = 3,
    parameter int PRE_CODE   = 2,
    parameter int AREF_CODE  = 4
) (
    input  step_e        step,
    input  logic         hi,
    input  logic [W-1:0] base,
    input  logic [W-1:0] mode,
    input  logic [W-1:0] emode,
    output logic [W-1:0] word,
    output logic         to_mode
);

    localparam logic [CODE_W-1:0] CODE_NONE = '0;
    localparam logic [CODE_W-1:0] CODE_PRE  = CODE_W'(PRE_CODE);
    localparam logic [CODE_W-1:0] CODE_AREF = CODE_W'(AREF_CODE);

    // Base word with unlock, address-mode and command fields replaced.
    function automatic logic [W-1:0] ctrl_word(logic [CODE_W-1:0] code, logic unlock);
        logic [W-1:0] w;
        w                 = base;
        w[UNLOCK_BIT]     = unlock;
        w[HIADDR_BIT]     = hi;
        w[CODE_W-1:0]     = code;
        return w;
    endfunction

    // Select the word for the present step.
    always_comb begin
        to_mode = targets_mode(step);
        case (step)
            ST_UNLOCK: word = ctrl_word(CODE_NONE, 1'b1);
            ST_PRE1,
            ST_PRE2:   word = ctrl_word(CODE_PRE, 1'b1);
            ST_EMODE:  word = emode;
            ST_DLLRST: word = mode | (W'(1) << DLLRST_BIT);
            ST_AREF:   word = ctrl_word(CODE_AREF, 1'b1);
            ST_MODE:   word = mode;
            ST_NORMAL: word = ctrl_word(CODE_NONE, 1'b0);
            default:   word = '0;
        endcase
    end

endmodule

// File: rtl/sdram_init_seq.sv
// Top: SDRAM / DDR SDRAM power-up command sequencer. Offers one command at a
// time on a valid/ready port. Assumes the downstream holds off nothing else.
module sdram_init_seq
    import sdinit_pkg::*;
#(
    parameter int W          = 32,
    parameter int UNLOCK_BIT = 31,
    parameter int HIADDR_BIT = 24,
    parameter int DLLRST_BIT = 26,
    parameter int CODE_W     = 3,
    parameter int PRE_CODE   = 2,
    parameter int AREF_CODE  = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         ddr_sel,
    input  logic         hi_addr,
    input  logic [W-1:0] ctrl_base,
    input  logic [W-1:0] mode_word,
    input  logic [W-1:0] ext_mode_word,
    output logic         cmd_valid,
    input  logic         cmd_ready,
    output logic         cmd_to_mode,
    output logic [W-1:0] cmd_word,
    output logic         done
);

    step_e        step;
    logic         busy;
    logic         capture;
    logic         cfg_ddr;
    logic         cfg_hi;
    logic [W-1:0] cfg_base;
    logic [W-1:0] cfg_mode;
    logic [W-1:0] cfg_emode;

    sdinit_cfg_latch #(.W(W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .d_ddr   (ddr_sel),
        .d_hi    (hi_addr),
        .d_base  (ctrl_base),
        .d_mode  (mode_word),
        .d_emode (ext_mode_word),
        .q_ddr   (cfg_ddr),
        .q_hi    (cfg_hi),
        .q_base  (cfg_base),
        .q_mode  (cfg_mode),
        .q_emode (cfg_emode)
    );

    sdinit_seq_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .ddr     (cfg_ddr),
        .accept  (cmd_ready),
        .step    (step),
        .busy    (busy),
        .capture (capture),
        .done    (done)
    );

    sdinit_word_mux #(
        .W          (W),
        .UNLOCK_BIT (UNLOCK_BIT),
        .HIADDR_BIT (HIADDR_BIT),
        .DLLRST_BIT (DLLRST_BIT),
        .CODE_W     (CODE_W),
        .PRE_CODE   (PRE_CODE),
        .AREF_CODE  (AREF_CODE)
    ) u_mux (
        .step    (step),
        .hi      (cfg_hi),
        .base    (cfg_base),
        .mode    (cfg_mode),
        .emode   (cfg_emode),
        .word    (cmd_word),
        .to_mode (cmd_to_mode)
    );

    // A command is offered in every non-idle step.
    always_comb begin
        cmd_valid = busy;
    end

endmodule

// File: rtl/sdinit_chk.sv
// Checker: handshake, completion and field properties of the sequencer.
module sdinit_chk #(
    parameter int W          = 32,
    parameter int UNLOCK_BIT = 31,
    parameter int HIADDR_BIT = 24
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic         cfg_hi,
    input logic         cmd_valid,
    input logic         cmd_ready,
    input logic         cmd_to_mode,
    input logic [W-1:0] cmd_word,
    input logic         done
);

    // R6
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_word) && $stable(cmd_to_mode));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    done_after_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !cmd_valid && $past(cmd_valid && cmd_ready && !cmd_to_mode && !cmd_word[UNLOCK_BIT]));

    // R5
    hiaddr_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_to_mode |-> cmd_word[HIADDR_BIT] == cfg_hi);

    // R2
    first_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy |=> cmd_valid && !cmd_to_mode && cmd_word[UNLOCK_BIT]);

    // R9
    handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready && (cmd_to_mode || cmd_word[UNLOCK_BIT]) |=> cmd_valid);

endmodule

bind sdram_init_seq sdinit_chk #(
    .W          (W),
    .UNLOCK_BIT (UNLOCK_BIT),
    .HIADDR_BIT (HIADDR_BIT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .busy        (busy),
    .cfg_hi      (cfg_hi),
    .cmd_valid   (cmd_valid),
    .cmd_ready   (cmd_ready),
    .cmd_to_mode (cmd_to_mode),
    .cmd_word    (cmd_word),
    .done        (done)
);

// File: tb/sdram_init_seq_test.sv
module sdram_init_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        ddr_sel = 1'b0;
    logic        hi_addr = 1'b0;
    logic [31:0] ctrl_base = '0;
    logic [31:0] mode_word = '0;
    logic [31:0] ext_mode_word = '0;
    logic        cmd_ready = 1'b0;
    logic        cmd_valid;
    logic        cmd_to_mode;
    logic [31:0] cmd_word;
    logic        done;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    sdram_init_seq uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .ddr_sel       (ddr_sel),
        .hi_addr       (hi_addr),
        .ctrl_base     (ctrl_base),
        .mode_word     (mode_word),
        .ext_mode_word (ext_mode_word),
        .cmd_valid     (cmd_valid),
        .cmd_ready     (cmd_ready),
        .cmd_to_mode   (cmd_to_mode),
        .cmd_word      (cmd_word),
        .done          (done)
    );

    typedef struct packed {
        logic        ddr;
        logic        hi;
        logic [1:0]  gap;
        logic [31:0] base;
        logic [31:0] mode;
        logic [31:0] emode;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{1'b0, 1'b0, 2'd0, 32'h0000_0000, 32'h0063_0000, 32'h0000_0000},
        '{1'b0, 1'b1, 2'd1, 32'h7000_0F00, 32'h008D_0000, 32'h4000_0000},
        '{1'b1, 1'b0, 2'd0, 32'h5041_0000, 32'h0131_0000, 32'h4000_0000},
        '{1'b1, 1'b1, 2'd2, 32'hFFFF_FFFF, 32'h0133_0000, 32'h4001_0000},
        '{1'b1, 1'b0, 2'd3, 32'h8100_0007, 32'hFFFF_FFFF, 32'h1234_5678},
        '{1'b0, 1'b1, 2'd0, 32'h0123_4567, 32'h0400_0000, 32'h0BAD_F00D}
    };

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Expected {target, word} for command k of a sequence, from R3/R4/R5.
    function automatic logic [32:0] expect_cmd(int k, vec_t v);
        int id;
        logic [31:0] c;
        if (v.ddr) id = k;
        else begin
            case (k)
                0: id = 0;
                1: id = 1;
                2: id = 5;
                3: id = 6;
                default: id = 7;
            endcase
        end
        c = v.base;
        c[24] = v.hi;
        case (id)
            0: begin c[31] = 1'b1; c[2:0] = 3'd0; return {1'b0, c}; end
            1, 4: begin c[31] = 1'b1; c[2:0] = 3'd2; return {1'b0, c}; end
            2: return {1'b1, v.emode};
            3: return {1'b1, v.mode | 32'h0400_0000};
            5: begin c[31] = 1'b1; c[2:0] = 3'd4; return {1'b0, c}; end
            6: return {1'b1, v.mode};
            default: begin c[31] = 1'b0; c[2:0] = 3'd0; return {1'b0, c}; end
        endcase
    endfunction

    // Run one full sequence; disturb changes inputs and holds start mid-run (R8).
    task automatic run_seq(vec_t v, bit disturb);
        int n;
        logic [32:0] e;
        n = v.ddr ? 8 : 5;
        ddr_sel = v.ddr;
        hi_addr = v.hi;
        ctrl_base = v.base;
        mode_word = v.mode;
        ext_mode_word = v.emode;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < n; k++) begin
            e = expect_cmd(k, v);
            check(v.ddr ? "R4 valid" : "R3 valid", {63'd0, cmd_valid}, 64'd1);
            check(v.ddr ? "R4 R5 word" : "R3 R5 word", {31'd0, cmd_to_mode, cmd_word}, {31'd0, e});
            if (disturb) begin
                ddr_sel = ~v.ddr;
                hi_addr = ~v.hi;
                ctrl_base = ~v.base;
                mode_word = ~v.mode;
                ext_mode_word = ~v.emode;
                start = (k < n - 1);
            end
            if (v.gap == 2'd0) begin
                cmd_ready = 1'b1;
            end else begin
                cmd_ready = 1'b0;
                for (int g = 0; g < int'(v.gap); g++) begin
                    @(negedge clk);
                    check("R6 held", {30'd0, cmd_valid, cmd_to_mode, cmd_word}, {30'd0, 1'b1, e});
                end
                cmd_ready = 1'b1;
            end
            @(negedge clk);
            if (k == 0 && v.gap == 2'd0)
                check("R9 next command", {63'd0, cmd_valid}, 64'd1);
        end
        cmd_ready = 1'b0;
        start = 1'b0;
        check("R7 done high", {62'd0, done, cmd_valid}, {62'd0, 1'b1, 1'b0});
        @(negedge clk);
        check("R7 done one cycle", {62'd0, done, cmd_valid}, {62'd0, 1'b0, 1'b0});
    endtask

    initial begin
        // Reset state (R1)
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset valid", {63'd0, cmd_valid}, 64'd0);
        check("R1 reset done", {63'd0, done}, 64'd0);
        rst_n = 1'b1;
        cmd_ready = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 idle no command", {62'd0, cmd_valid, done}, 64'd0);
        cmd_ready = 1'b0;

        for (int i = 0; i < 6; i++) begin
            run_seq(VEC[i], 1'b0);
        end

        // Inputs and start ignored while running (R8)
        run_seq(VEC[2], 1'b1);
        run_seq(VEC[1], 1'b1);

        // Reset mid-sequence (R1)
        ddr_sel = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cmd_ready = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 mid-run still busy", {63'd0, cmd_valid}, 64'd1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset mid-run", {62'd0, cmd_valid, done}, 64'd0);
        rst_n = 1'b1;
        cmd_ready = 1'b0;
        @(negedge clk);
        check("R1 idle after reset", {63'd0, cmd_valid}, 64'd0);

        // Fresh start after reset begins with unlock (R2)
        run_seq(VEC[0], 1'b0);

        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule